// File: doc/BRIEF.md
# Byte-Programmed PWM Generator with Auto-Off Timer

This block produces one pulse-width-modulated output from a period and a high time. Both are counted in ticks of a fixed time base. Software programs the block through a write-only byte port, which carries an 8-bit address and 8 data bits. Each 16-bit quantity is split across two addresses. A write to the upper byte is only held in a staging register. The full value becomes active on the clock edge that writes the lower byte. Period and high time commit separately, so between those two writes the waveform runs with one new value and one old value.

An enable bit starts the output and stops it. An optional countdown, measured in milliseconds of ticks, clears the enable by itself when it expires. The value 0xFFFF turns the countdown off. The output polarity is fixed: the output is high at the start of each period.

Top module: `bytepwm_top`

## Requirements
- R1: After reset the output is low, the enable is clear, the active period and high time are zero, and the auto-off value is 0xFFFF (disabled). Setting the enable straight after reset therefore leaves the output low.
- R2: A write to an upper-byte address changes nothing active. These addresses are 0xA1 (auto-off), 0xA5 (period) and 0xA7 (high time). Such a write only stages the byte.
- R3: A write to a lower-byte address replaces the matching active value with {staged upper byte, written byte} on that clock edge. The lower-byte addresses are 0xA2 (auto-off), 0xA4 (period) and 0xA6 (high time). Period and high time commit independently of each other.
- R4: One tick lasts TICK_DIV clocks. The tick counter runs from 0 to period−1 and then wraps. The output is high while the counter is below the high time. After an enabling write, the counter is 0 in the first clock and advances every TICK_DIV clocks.
- R5: A high time equal to or above the period gives a constantly high output. A high time of zero gives a constantly low output.
- R6: An active period of zero holds the output low while the block is enabled.
- R7: Bit 0 of a write to address 0xA3 sets or clears the enable. When the enable is clear, the output is low and the tick counter is held at zero.
- R8: Writing the enable to 1 loads the auto-off countdown with the active auto-off value N. If N is not 0xFFFF, the enable clears after exactly N·MS_TICKS·TICK_DIV clocks, and a value of 0 acts as 1. The output then stays low until the enable is written again.
- R9: With auto-off 0xFFFF at the enabling write, the enable never clears by itself.
- R10: Writes to addresses outside 0xA1 to 0xA7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick is TICK_DIV cycles |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| wrAddr | input | 8 | Register address |
| wrData | input | 8 | Write data byte |
| pwmOut | output | 1 | PWM output, active high |

## Verification
The waveform is swept over every period from 1 to 6 ticks. Each period is paired with every high time from 0 up to one past the period. Every clock is compared against the closed-form count `(k / TICK_DIV) mod P < D`, which separates off-by-one errors in the wrap, the comparator and the tick divider.

Separate sequences handle the upper-byte writes:
- An upper-byte write alone is issued while the output runs, and the high-clock count over a window shows that nothing changed.
- A lone period commit shows that the high time is kept.
- A zero period is tried as its own case.

Auto-off is tried with values 2, 0 and 0xFFFF. The exact clock of the turn-off is checked, which tells a late or early countdown apart from a correct one. Writes to unused addresses, including aliases that differ from a real address only in bit 7, are placed before an exact-waveform check.

// File: rtl/bytepwm_pkg.sv
package bytepwm_pkg;
  localparam int VAL_W = 16;

  localparam logic [7:0] A_AOFF_HI = 8'hA1;
  localparam logic [7:0] A_AOFF_LO = 8'hA2;
  localparam logic [7:0] A_ENABLE  = 8'hA3;
  localparam logic [7:0] A_PER_LO  = 8'hA4;
  localparam logic [7:0] A_PER_HI  = 8'hA5;
  localparam logic [7:0] A_DUTY_LO = 8'hA6;
  localparam logic [7:0] A_DUTY_HI = 8'hA7;

  localparam logic [VAL_W-1:0] AOFF_NEVER = '1;

  typedef struct packed {
    logic             run;
    logic [VAL_W-1:0] period;
    logic [VAL_W-1:0] duty;
  } ctl_bus_t;
endpackage

// File: rtl/bytepwm_ctrl.sv
module bytepwm_ctrl
  import bytepwm_pkg::*;
#(
  parameter int MS_TICKS = 8000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       tick,
  output ctl_bus_t   ctl,
  output logic       armedO,
  output logic [7:0] perStgO
);
  localparam int MS_W = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_TICKS - 1);

  logic [7:0]       perStg, dutyStg, aoffStg;
  logic [VAL_W-1:0] period, duty, aoffVal, remain;
  logic             run, armed;
  logic [MS_W-1:0]  msCnt;
  logic             enWrite;

  assign enWrite = wrEn && (wrAddr == A_ENABLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perStg  <= '0;
      dutyStg <= '0;
      aoffStg <= '0;
      period  <= '0;
      duty    <= '0;
      aoffVal <= AOFF_NEVER;
      remain  <= '0;
      run     <= 1'b0;
      armed   <= 1'b0;
      msCnt   <= '0;
    end else begin
      if (wrEn) begin
        case (wrAddr)
          A_AOFF_HI: aoffStg <= wrData;
          A_AOFF_LO: aoffVal <= {aoffStg, wrData};
          A_PER_HI:  perStg  <= wrData;
          A_PER_LO:  period  <= {perStg, wrData};
          A_DUTY_HI: dutyStg <= wrData;
          A_DUTY_LO: duty    <= {dutyStg, wrData};
          A_ENABLE: begin
            run   <= wrData[0];
            armed <= wrData[0] && (aoffVal != AOFF_NEVER);
            remain <= aoffVal;
            msCnt <= '0;
          end
          default: ;
        endcase
      end
      // millisecond countdown, suspended in the cycle of an enable write
      if (run && armed && tick && !enWrite) begin
        if (msCnt == MS_LAST) begin
          msCnt <= '0;
          if (remain <= VAL_W'(1)) begin
            run   <= 1'b0;
            armed <= 1'b0;
          end else begin
            remain <= remain - VAL_W'(1);
          end
        end else begin
          msCnt <= msCnt + MS_W'(1);
        end
      end
    end
  end

  assign ctl.run    = run;
  assign ctl.period = period;
  assign ctl.duty   = duty;
  assign armedO     = armed;
  assign perStgO    = perStg;
endmodule

// File: rtl/bytepwm_dpath.sv
module bytepwm_dpath
  import bytepwm_pkg::*;
#(
  parameter int TICK_DIV = 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctl_bus_t ctl,
  output logic     tick,
  output logic     pwmOut
);
  localparam int PS_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [VAL_W-1:0] cnt;

  generate
    if (TICK_DIV > 1) begin : g_div
      localparam logic [PS_W-1:0] PS_LAST = PS_W'(TICK_DIV - 1);
      logic [PS_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !ctl.run) preCnt <= '0;
        else if (preCnt == PS_LAST) preCnt <= '0;
        else preCnt <= preCnt + PS_W'(1);
      end
      assign tick = ctl.run && (preCnt == PS_LAST);
    end else begin : g_nodiv
      assign tick = ctl.run;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.run) begin
      cnt <= '0;
    end else if (tick) begin
      if (ctl.period == '0 || cnt >= ctl.period - VAL_W'(1)) cnt <= '0;
      else cnt <= cnt + VAL_W'(1);
    end
  end

  assign pwmOut = ctl.run && (ctl.period != '0) &&
                  ((cnt < ctl.duty) || (ctl.duty >= ctl.period));
endmodule

// File: rtl/bytepwm_top.sv
module bytepwm_top
  import bytepwm_pkg::*;
#(
  parameter int TICK_DIV = 1,
  parameter int MS_TICKS = 8000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       pwmOut
);
  ctl_bus_t         ctlBus;
  logic             tick;
  logic             armed;
  logic [7:0]       perStg;
  logic             runNow;
  logic [VAL_W-1:0] perNow, dutyNow;

  bytepwm_ctrl #(.MS_TICKS(MS_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tick(tick), .ctl(ctlBus), .armedO(armed), .perStgO(perStg)
  );

  bytepwm_dpath #(.TICK_DIV(TICK_DIV)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .tick(tick), .pwmOut(pwmOut)
  );

  assign runNow  = ctlBus.run;
  assign perNow  = ctlBus.period;
  assign dutyNow = ctlBus.duty;
endmodule

// File: rtl/bytepwm_chk.sv
module bytepwm_chk
  import bytepwm_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [7:0]       wrAddr,
  input logic [7:0]       wrData,
  input logic             pwmOut,
  input logic             runNow,
  input logic             armed,
  input logic [7:0]       perStg,
  input logic [VAL_W-1:0] perNow,
  input logic [VAL_W-1:0] dutyNow
);
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_PER_HI) |=> $stable(perNow)); // R2

  AST_PER_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_PER_LO) |=> perNow == {$past(perStg), $past(wrData)}); // R3

  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (runNow && perNow != '0 && dutyNow >= perNow) |-> pwmOut); // R5

  AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (perNow == '0) |-> !pwmOut); // R6

  AST_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !runNow |-> !pwmOut); // R7

  AST_NO_AUTO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (runNow && !armed && !(wrEn && wrAddr == A_ENABLE)) |=> runNow); // R9
endmodule

bind bytepwm_top bytepwm_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .pwmOut(pwmOut), .runNow(runNow), .armed(armed), .perStg(perStg),
  .perNow(perNow), .dutyNow(dutyNow)
);

// File: tb/sim_bytepwm_top.sv
`timescale 1ns/1ps
module sim_bytepwm_top;
  localparam int DIV = 2;
  localparam int MST = 4;
  localparam int MS_CLK = DIV * MST;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic pwmOut;
  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bytepwm_top #(.TICK_DIV(DIV), .MS_TICKS(MST)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut)
  );

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic check(input bit exp, input string req, input int k);
    nChk++;
    if (pwmOut !== exp) begin
      nBad++;
      $display("FAIL %s clock %0d: pwmOut=%0b expected=%0b", req, k, pwmOut, exp);
    end
  endtask

  task automatic checkCount(input int n, input int exp, input string req);
    int c = 0;
    for (int i = 0; i < n; i++) begin
      if (pwmOut === 1'b1) c++;
      @(negedge clk);
    end
    nChk++;
    if (c != exp) begin
      nBad++;
      $display("FAIL %s high clocks=%0d expected=%0d", req, c, exp);
    end
  endtask

  task automatic setVals(input int p, input int d);
    wr(8'hA5, 8'(p >> 8)); wr(8'hA4, 8'(p));
    wr(8'hA7, 8'(d >> 8)); wr(8'hA6, 8'(d));
  endtask

  // expected waveform: clock k after the enabling write, auto-off after offClk
  function automatic bit model(int k, int p, int d, int offClk);
    if (offClk >= 0 && k >= offClk) return 1'b0;
    if (p == 0 || d == 0) return 1'b0;
    return ((k / DIV) % p) < d;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 reset", 0);
    // R1 R6: zero period after reset keeps the output low
    wr(8'hA3, 8'h01);
    for (int k = 0; k < 12; k++) begin check(1'b0, "R1 R6", k); @(negedge clk); end
    wr(8'hA3, 8'h00);

    // R4 R5 R10: sweep period and high time, exact per-clock comparison
    for (int p = 1; p <= 6; p++) begin
      for (int d = 0; d <= p + 1; d++) begin
        wr(8'hA3, 8'h00);
        setVals(p, d);
        wr(8'hA0, 8'hFF); wr(8'hA8, 8'h00); wr(8'h24, 8'h00); wr(8'h26, 8'h00);
        wr(8'hA3, 8'h01);
        for (int k = 0; k < 3 * p * DIV; k++) begin
          check(model(k, p, d, -1), (d == 0 || d >= p) ? "R5 R10" : "R4 R10", k);
          @(negedge clk);
        end
      end
    end

    // R2 R3 staging and independent commit
    wr(8'hA3, 8'h00);
    setVals(4, 2);
    wr(8'hA3, 8'h01);
    wr(8'hA7, 8'h01);
    checkCount(4 * DIV * 2, 2 * DIV * 2, "R2 duty upper byte held");
    wr(8'hA6, 8'h00);
    checkCount(16, 16, "R3 R5 duty 0x0100 committed");
    wr(8'hA7, 8'h00); wr(8'hA6, 8'h02);
    wr(8'hA4, 8'h08);
    checkCount(8 * DIV, 2 * DIV, "R3 period alone committed");
    wr(8'hA5, 8'h01);
    checkCount(8 * DIV, 2 * DIV, "R2 period upper byte held");
    wr(8'hA5, 8'h00); wr(8'hA4, 8'h00);
    checkCount(12, 0, "R6 zero period");

    // R7 enable clear forces low, bit 0 only
    setVals(2, 1);
    wr(8'hA3, 8'h01);
    checkCount(8, 4, "R7 enabled");
    wr(8'hA3, 8'hFE);
    checkCount(10, 0, "R7 bit0 clear");

    // R8 auto-off after 2 ms
    wr(8'hA1, 8'h00); wr(8'hA2, 8'h02);
    wr(8'hA3, 8'h01);
    for (int k = 0; k < 2 * MS_CLK + 10; k++) begin
      check(model(k, 2, 1, 2 * MS_CLK), "R8 N=2", k); @(negedge clk);
    end
    // R8 value 0 acts as one ms
    wr(8'hA2, 8'h00);
    wr(8'hA3, 8'h01);
    for (int k = 0; k < MS_CLK + 10; k++) begin
      check(model(k, 2, 1, MS_CLK), "R8 N=0", k); @(negedge clk);
    end
    // R9 0xFFFF disables auto-off
    wr(8'hA1, 8'hFF); wr(8'hA2, 8'hFF);
    wr(8'hA3, 8'h01);
    for (int k = 0; k < 40 * MS_CLK; k++) begin
      check(model(k, 2, 1, -1), "R9", k); @(negedge clk);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule